// File: doc/BRIEF.md
# Machine State Register Write Controller

This block owns a processor's machine state register and turns every software write into an architecturally legal committed value. A write is filtered before it is stored. Bits that the implementation lacks are dropped. The hypervisor bit is protected. In server-class operation, entering user mode forces translation and external interrupts on. The block then compares the committed value with the previous one and raises one-cycle pulses for the neighbouring logic. One pulse asks for a translation-context flush. Another asks the register file to exchange its low general registers with their shadow bank. The exception vector base follows a prefix bit.

From the committed register the block derives a small flags word. It holds one translation-mode index for instruction fetch and one for data access, a hypervisor flag and a copy of the user bit. It also raises a halt request while the power-management bit is set and no interrupt is pending. Configuration straps are quasi-static inputs. They select the implemented-bit mask, server-class forcing, the embedded MMU index scheme, the shadow-register feature and whether a hypervisor mode exists.

Top module: `msr_write_ctrl`

Register bit positions used below: HV=60, GS=28, POW=18, TGPR=17, EE=15, PR=14, IAS=11, DAS=10, EPFX=6, IT=5, DT=4.
Flags word: [2:0] instruction index, [5:3] data index, [6] hypervisor flag, [7] user bit.

## Requirements
- R1: On a write, the value is first ANDed with impl_mask_i. Every bit other than HV, EE, IT and DT is committed as (wr_data_i & impl_mask_i).
- R2: The committed HV bit keeps its old value unless allow_hv_i is 1 and the old HV bit is 1. In that case the HV bit comes from the masked write value.
- R3: flush_o is high for exactly the cycle after a write whose committed IT or DT bit differs from the previous IT or DT bit.
- R4: With embedded_mmu_i=1, a change of the committed GS bit also raises flush_o. With embedded_mmu_i=0, a GS change alone does not raise it.
- R5: With tgpr_en_i=1, swap_o is high for exactly the cycle after a write that toggles the TGPR bit. With tgpr_en_i=0, swap_o stays low.
- R6: After a write that changes the EPFX bit, exc_base_o is 0xFFF00000 if the new EPFX bit is 1 and 0 if it is 0. Otherwise exc_base_o is unchanged.
- R7: With server_mode_i=1, if the masked write value has PR=1, then EE, IT and DT are committed as 1 whatever the write value or mask holds.
- R8: halt_o equals committed POW AND NOT irq_pending_i.
- R9: With embedded_mmu_i=0, each index has bit0 = NOT PR and bit2 = HV. Bit1 is NOT IT for the instruction index and NOT DT for the data index. flags_o[7] is PR.
- R10: With embedded_mmu_i=1, each index has bit0 = NOT PR and bit2 = GS. Bit1 is IAS for the instruction index and DAS for the data index.
- R11: flags_o[6] is 1 when hv_present_i is 0 or the committed HV bit is 1.
- R12: The register and the registered outputs change only on the clock edge after wr_en_i. The pulses are low in any cycle that does not follow a write. Reset sets the register to RST_MSR (default 0), exc_base_o to 0, and flush_o and swap_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | XLEN | Value software writes |
| allow_hv_i | input | 1 | Write may change the HV bit |
| impl_mask_i | input | XLEN | Implemented-bit mask |
| server_mode_i | input | 1 | Server-class user-mode forcing enable |
| embedded_mmu_i | input | 1 | Embedded MMU index scheme select |
| tgpr_en_i | input | 1 | Shadow register bank feature present |
| hv_present_i | input | 1 | Hypervisor mode feature present |
| irq_pending_i | input | 1 | An interrupt is pending |
| msr_o | output | XLEN | Committed register |
| flags_o | output | 8 | Derived flags and translation indices |
| flush_o | output | 1 | Translation-context flush pulse |
| swap_o | output | 1 | Register bank swap pulse |
| exc_base_o | output | ADDR_W | Exception vector base |
| halt_o | output | 1 | Halt request |

## Verification
A corrupted committed register shows on msr_o, flags_o and halt_o in the very next cycle, because all of them decode the stored value directly. A wrong old value used for comparison shows only at the following write, as a missing or extra flush or swap pulse. A stale or wrong exception base stays visible until the next prefix change. Since HV can only be cleared, never raised, by a write, a mistake in its protection is permanent until reset. The sweep therefore resets between configurations and runs a second instance that starts with HV set.

// File: rtl/msr_ctrl_pkg.sv
package msr_ctrl_pkg;
  localparam int MSR_HV   = 60;
  localparam int MSR_GS   = 28;
  localparam int MSR_POW  = 18;
  localparam int MSR_TGPR = 17;
  localparam int MSR_EE   = 15;
  localparam int MSR_PR   = 14;
  localparam int MSR_IAS  = 11;
  localparam int MSR_DAS  = 10;
  localparam int MSR_EPFX = 6;
  localparam int MSR_IT   = 5;
  localparam int MSR_DT   = 4;

  localparam int IDX_W    = 3;
  localparam int N_IDX    = 2;  // 0: instruction, 1: data
  localparam int FLAG_W   = N_IDX * IDX_W + 2;
  localparam int FLG_HV   = N_IDX * IDX_W;
  localparam int FLG_USER = N_IDX * IDX_W + 1;
endpackage

// File: rtl/msr_filter.sv
module msr_filter
  import msr_ctrl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            allow_hv_i,
  input  logic            server_i,
  output logic [XLEN-1:0] new_o
);
  logic hv_keep;

  assign hv_keep = !(allow_hv_i && old_i[MSR_HV]);

  always_comb begin
    new_o = wdata_i & mask_i;
    if (hv_keep) new_o[MSR_HV] = old_i[MSR_HV];
    // user mode on server parts cannot run untranslated or masked
    if (server_i && new_o[MSR_PR]) begin
      new_o[MSR_EE] = 1'b1;
      new_o[MSR_IT] = 1'b1;
      new_o[MSR_DT] = 1'b1;
    end
  end
endmodule

// File: rtl/msr_side_fx.sv
module msr_side_fx (
  input  logic old_it_i,
  input  logic new_it_i,
  input  logic old_dt_i,
  input  logic new_dt_i,
  input  logic old_gs_i,
  input  logic new_gs_i,
  input  logic old_tg_i,
  input  logic new_tg_i,
  input  logic old_ep_i,
  input  logic new_ep_i,
  input  logic embedded_i,
  input  logic tgpr_en_i,
  output logic flush_o,
  output logic swap_o,
  output logic pfx_chg_o
);
  logic xlat_chg, gs_chg;

  assign xlat_chg  = (old_it_i ^ new_it_i) | (old_dt_i ^ new_dt_i);
  assign gs_chg    = embedded_i & (old_gs_i ^ new_gs_i);
  assign flush_o   = xlat_chg | gs_chg;
  assign swap_o    = tgpr_en_i & (old_tg_i ^ new_tg_i);
  assign pfx_chg_o = old_ep_i ^ new_ep_i;
endmodule

// File: rtl/msr_mode_idx.sv
module msr_mode_idx
  import msr_ctrl_pkg::*;
(
  input  logic             user_i,
  input  logic             hv_i,
  input  logic             gs_i,
  input  logic             xlat_i,
  input  logic             as_i,
  input  logic             embedded_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o[0] = ~user_i;
  assign idx_o[1] = embedded_i ? as_i : ~xlat_i;
  assign idx_o[2] = embedded_i ? gs_i : hv_i;
endmodule

// File: rtl/msr_write_ctrl.sv
module msr_write_ctrl
  import msr_ctrl_pkg::*;
#(
  parameter int                 XLEN        = 64,
  parameter int                 ADDR_W      = 32,
  parameter logic [ADDR_W-1:0]  PREFIX_BASE = 32'hFFF0_0000,
  parameter logic [XLEN-1:0]    RST_MSR     = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              allow_hv_i,
  input  logic [XLEN-1:0]   impl_mask_i,
  input  logic              server_mode_i,
  input  logic              embedded_mmu_i,
  input  logic              tgpr_en_i,
  input  logic              hv_present_i,
  input  logic              irq_pending_i,
  output logic [XLEN-1:0]   msr_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              flush_o,
  output logic              swap_o,
  output logic [ADDR_W-1:0] exc_base_o,
  output logic              halt_o
);
  logic [XLEN-1:0]   msr_q, msr_d;
  logic [ADDR_W-1:0] base_q;
  logic              flush_q, swap_q;
  logic              flush_d, swap_d, pfx_chg;
  logic [IDX_W-1:0]  idx [N_IDX];

  msr_filter #(.XLEN(XLEN)) u_filter (
    .old_i      (msr_q),
    .wdata_i    (wr_data_i),
    .mask_i     (impl_mask_i),
    .allow_hv_i (allow_hv_i),
    .server_i   (server_mode_i),
    .new_o      (msr_d)
  );

  msr_side_fx u_side_fx (
    .old_it_i   (msr_q[MSR_IT]),
    .new_it_i   (msr_d[MSR_IT]),
    .old_dt_i   (msr_q[MSR_DT]),
    .new_dt_i   (msr_d[MSR_DT]),
    .old_gs_i   (msr_q[MSR_GS]),
    .new_gs_i   (msr_d[MSR_GS]),
    .old_tg_i   (msr_q[MSR_TGPR]),
    .new_tg_i   (msr_d[MSR_TGPR]),
    .old_ep_i   (msr_q[MSR_EPFX]),
    .new_ep_i   (msr_d[MSR_EPFX]),
    .embedded_i (embedded_mmu_i),
    .tgpr_en_i  (tgpr_en_i),
    .flush_o    (flush_d),
    .swap_o     (swap_d),
    .pfx_chg_o  (pfx_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q   <= RST_MSR;
      base_q  <= '0;
      flush_q <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      flush_q <= wr_en_i & flush_d;
      swap_q  <= wr_en_i & swap_d;
      if (wr_en_i) begin
        msr_q <= msr_d;
        if (pfx_chg) base_q <= msr_d[MSR_EPFX] ? PREFIX_BASE : '0;
      end
    end
  end

  for (genvar k = 0; k < N_IDX; k++) begin : g_idx
    localparam int XLAT_POS = (k == 0) ? MSR_IT  : MSR_DT;
    localparam int AS_POS   = (k == 0) ? MSR_IAS : MSR_DAS;
    msr_mode_idx u_idx (
      .user_i     (msr_q[MSR_PR]),
      .hv_i       (msr_q[MSR_HV]),
      .gs_i       (msr_q[MSR_GS]),
      .xlat_i     (msr_q[XLAT_POS]),
      .as_i       (msr_q[AS_POS]),
      .embedded_i (embedded_mmu_i),
      .idx_o      (idx[k])
    );
    assign flags_o[k*IDX_W +: IDX_W] = idx[k];
  end

  assign flags_o[FLG_HV]   = ~hv_present_i | msr_q[MSR_HV];
  assign flags_o[FLG_USER] = msr_q[MSR_PR];

  assign msr_o      = msr_q;
  assign flush_o    = flush_q;
  assign swap_o     = swap_q;
  assign exc_base_o = base_q;
  assign halt_o     = msr_q[MSR_POW] & ~irq_pending_i;
endmodule

// File: rtl/msr_write_ctrl_chk.sv
module msr_write_ctrl_chk
  import msr_ctrl_pkg::*;
#(
  parameter int                XLEN        = 64,
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] PREFIX_BASE = 32'hFFF0_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [XLEN-1:0]   wr_data_i,
  input logic              allow_hv_i,
  input logic [XLEN-1:0]   impl_mask_i,
  input logic              server_mode_i,
  input logic              embedded_mmu_i,
  input logic              tgpr_en_i,
  input logic              hv_present_i,
  input logic              irq_pending_i,
  input logic [XLEN-1:0]   msr_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              flush_o,
  input logic              swap_o,
  input logic [ADDR_W-1:0] exc_base_o,
  input logic              halt_o
);
  localparam logic [XLEN-1:0] SPECIAL = (XLEN'(1) << MSR_HV) | (XLEN'(1) << MSR_EE) |
                                        (XLEN'(1) << MSR_IT) | (XLEN'(1) << MSR_DT);

  p_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (((msr_o ^ $past(wr_data_i)) & $past(impl_mask_i) & ~SPECIAL) == '0) &&
                ((msr_o & ~$past(impl_mask_i) & ~SPECIAL) == '0));

  p_hv_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(allow_hv_i && msr_o[MSR_HV])) |=> msr_o[MSR_HV] == $past(msr_o[MSR_HV]));

  p_flush_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> flush_o == ((msr_o[MSR_IT] != $past(msr_o[MSR_IT])) ||
                            (msr_o[MSR_DT] != $past(msr_o[MSR_DT])) ||
                            ($past(embedded_mmu_i) && (msr_o[MSR_GS] != $past(msr_o[MSR_GS])))));

  p_swap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> swap_o == ($past(tgpr_en_i) && (msr_o[MSR_TGPR] != $past(msr_o[MSR_TGPR]))));

  p_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> exc_base_o == (msr_o[MSR_EPFX] ? PREFIX_BASE : '0));

  p_user_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && server_mode_i && wr_data_i[MSR_PR] && impl_mask_i[MSR_PR])
      |=> msr_o[MSR_EE] && msr_o[MSR_IT] && msr_o[MSR_DT]);

  p_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pending_i |-> !halt_o);

  p_idx_plain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !embedded_mmu_i |-> (flags_o[1] == !msr_o[MSR_IT]) && (flags_o[4] == !msr_o[MSR_DT]) &&
                        (flags_o[FLG_USER] == msr_o[MSR_PR]) && (flags_o[0] == flags_o[3]));

  p_idx_emb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    embedded_mmu_i |-> (flags_o[2] == msr_o[MSR_GS]) && (flags_o[5] == msr_o[MSR_GS]));

  p_hvflag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_present_i |-> flags_o[FLG_HV]);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !flush_o && !swap_o && $stable(msr_o) && $stable(exc_base_o));
endmodule

bind msr_write_ctrl msr_write_ctrl_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .PREFIX_BASE(PREFIX_BASE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .allow_hv_i(allow_hv_i), .impl_mask_i(impl_mask_i), .server_mode_i(server_mode_i),
  .embedded_mmu_i(embedded_mmu_i), .tgpr_en_i(tgpr_en_i), .hv_present_i(hv_present_i),
  .irq_pending_i(irq_pending_i), .msr_o(msr_o), .flags_o(flags_o), .flush_o(flush_o),
  .swap_o(swap_o), .exc_base_o(exc_base_o), .halt_o(halt_o)
);

// File: tb/msr_write_ctrl_tb_top.sv
`timescale 1ns/100ps
module msr_write_ctrl_tb_top;
  localparam int B_HV = 60, B_GS = 28, B_POW = 18, B_TG = 17, B_EE = 15, B_PR = 14;
  localparam int B_IAS = 11, B_DAS = 10, B_EP = 6, B_IT = 5, B_DT = 4;
  localparam logic [63:0] HV_RST = 64'd1 << B_HV;
  localparam logic [63:0] ALT_MASK = 64'hF0F0_F0F0_F0F0_F0F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, allow_hv = 1'b0, server = 1'b0, emb = 1'b0, tg_en = 1'b0;
  logic hv_pres = 1'b0, pend = 1'b0;
  logic [63:0] wdata = '0, mask = '1;

  logic [63:0] msr_a, msr_b;
  logic [7:0]  flg_a, flg_b;
  logic        fl_a, fl_b, sw_a, sw_b, h_a, h_b;
  logic [31:0] base_a, base_b;

  int checks = 0, errors = 0;
  logic [63:0] em [2];
  logic [31:0] eb [2];
  logic        efl [2], esw [2];

  always #2.5 clk = ~clk;

  msr_write_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata), .allow_hv_i(allow_hv),
    .impl_mask_i(mask), .server_mode_i(server), .embedded_mmu_i(emb), .tgpr_en_i(tg_en),
    .hv_present_i(hv_pres), .irq_pending_i(pend), .msr_o(msr_a), .flags_o(flg_a),
    .flush_o(fl_a), .swap_o(sw_a), .exc_base_o(base_a), .halt_o(h_a));

  msr_write_ctrl #(.RST_MSR(HV_RST)) dut_hv_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata), .allow_hv_i(allow_hv),
    .impl_mask_i(mask), .server_mode_i(server), .embedded_mmu_i(emb), .tgpr_en_i(tg_en),
    .hv_present_i(hv_pres), .irq_pending_i(pend), .msr_o(msr_b), .flags_o(flg_b),
    .flush_o(fl_b), .swap_o(sw_b), .exc_base_o(base_b), .halt_o(h_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] spread(input logic [10:0] c);
    logic [63:0] v = '0;
    v[B_HV] = c[0]; v[B_GS] = c[1]; v[B_POW] = c[2]; v[B_TG] = c[3]; v[B_EE] = c[4];
    v[B_PR] = c[5]; v[B_IAS] = c[6]; v[B_DAS] = c[7]; v[B_EP] = c[8]; v[B_IT] = c[9];
    v[B_DT] = c[10];
    return v;
  endfunction

  function automatic logic [7:0] exp_flags(input logic [63:0] m);
    logic [7:0] f;
    f[0] = !m[B_PR];
    f[1] = emb ? m[B_IAS] : !m[B_IT];
    f[2] = emb ? m[B_GS]  : m[B_HV];
    f[3] = !m[B_PR];
    f[4] = emb ? m[B_DAS] : !m[B_DT];
    f[5] = emb ? m[B_GS]  : m[B_HV];
    f[6] = !hv_pres || m[B_HV];
    f[7] = m[B_PR];
    return f;
  endfunction

  function automatic void model_write(input int d);
    logic [63:0] o = em[d];
    logic [63:0] v = wdata & mask;
    if (!(allow_hv && o[B_HV])) v[B_HV] = o[B_HV];
    if (server && v[B_PR]) begin v[B_EE] = 1'b1; v[B_IT] = 1'b1; v[B_DT] = 1'b1; end
    efl[d] = (v[B_IT] != o[B_IT]) || (v[B_DT] != o[B_DT]) || (emb && (v[B_GS] != o[B_GS]));
    esw[d] = tg_en && (v[B_TG] != o[B_TG]);
    if (v[B_EP] != o[B_EP]) eb[d] = v[B_EP] ? 32'hFFF0_0000 : 32'h0;
    em[d] = v;
  endfunction

  task automatic check_after_write(input int d);
    logic [63:0] m  = d ? msr_b : msr_a;
    logic [7:0]  f  = d ? flg_b : flg_a;
    logic [63:0] keep = (64'd1 << B_HV) | (64'd1 << B_EE) | (64'd1 << B_IT) | (64'd1 << B_DT);
    logic [63:0] frc  = (64'd1 << B_EE) | (64'd1 << B_IT) | (64'd1 << B_DT);
    chk("R1 masked value", m & ~keep, em[d] & ~keep);
    chk("R2 hv bit", 64'(m[B_HV]), 64'(em[d][B_HV]));
    chk("R7 forced bits", m & frc, em[d] & frc);
    chk(emb ? "R4 flush" : "R3 flush", 64'(d ? fl_b : fl_a), 64'(efl[d]));
    chk("R5 swap", 64'(d ? sw_b : sw_a), 64'(esw[d]));
    chk("R6 base", 64'(d ? base_b : base_a), 64'(eb[d]));
    chk("R8 halt", 64'(d ? h_b : h_a), 64'(em[d][B_POW] && !pend));
    chk(emb ? "R10 indices" : "R9 indices", 64'(f[5:0]), 64'(exp_flags(em[d]) & 8'h3F));
    chk("R9 user flag", 64'(f[7]), 64'(em[d][B_PR]));
    chk("R11 hv flag", 64'(f[6]), 64'(exp_flags(em[d]) >> 6 & 8'h1));
  endtask

  task automatic check_idle(input int d);
    chk("R12 idle flush", 64'(d ? fl_b : fl_a), 64'd0);
    chk("R12 idle swap", 64'(d ? sw_b : sw_a), 64'd0);
    chk("R12 idle hold", d ? msr_b : msr_a, em[d]);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL R12 watchdog expired act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 32; cfg++) begin
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      server = cfg[0]; emb = cfg[1]; allow_hv = cfg[2]; tg_en = cfg[3];
      mask = cfg[4] ? ALT_MASK : '1;
      repeat (2) @(negedge clk);
      em[0] = '0; em[1] = HV_RST; eb[0] = '0; eb[1] = '0;
      chk("R12 reset msr", msr_a, 64'd0);
      chk("R12 reset msr hv", msr_b, HV_RST);
      chk("R12 reset base", 64'(base_a), 64'd0);
      chk("R12 reset pulses", 64'({fl_a, sw_a, fl_b, sw_b}), 64'd0);
      chk("R12 reset halt", 64'({h_a, h_b}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 1024; i++) begin
        logic [10:0] c = 11'((i * 1237 + cfg * 91) & 2047);
        logic [63:0] junk = {32'(i * 32'h9E37_79B9), 32'(int'(c) * 32'h85EB_CA6B)};
        wdata = spread(c) ^ (junk & ~spread(11'h7FF));
        hv_pres = i[3]; pend = i[2];
        wr_en = 1'b1;
        model_write(0); model_write(1);
        @(negedge clk);
        wr_en = 1'b0;
        check_after_write(0); check_after_write(1);
        @(negedge clk);
        check_idle(0); check_idle(1);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule